// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Buffer

This block sits beside the fetch stage of a small five-stage pipeline whose instruction addresses are eight bits wide and word aligned. Every cycle it looks up the current fetch address and proposes the next fetch address. It returns the stored branch target when two things are true: the direction counter for that address predicts taken, and the tagged target entry matches the address. In every other case it returns the fetch address plus four.

A table of direction counters and a tagged target store share one index, taken from address bits [3:2], so each has four entries. A later pipeline stage reports each resolved branch through the resolve port. That report carries the branch address, the real outcome and the computed target. The block trains its counter from the report and fills the target entry when the branch was taken.

In the same cycle, the block raises a mispredict flag based on the table contents that the fetch-time lookup would have seen. The parameter `CTR_BITS` selects the counter type. A value of 2 gives saturating two-bit counters and a value of 1 gives last-outcome bits.

Top module: `branch_predictor`

## Requirements
- R1: After reset, every two-bit counter holds 01 and every one-bit entry holds 0, and no target entry is valid. Every lookup therefore gives pred_taken=0, btb_hit=0 and next_pc = fetch_pc+4.
- R2: The entry index is address bits [3:2] and the tag is bits [7:4]. btb_hit is high only when the indexed entry is valid and its tag equals fetch_pc[7:4].
- R3: next_pc is the stored target when pred_taken and btb_hit are both high. Otherwise it is fetch_pc+4, taken modulo 256.
- R4: In two-bit mode, pred_taken is high for counter values 10 and 11. A taken outcome increments the counter and stops at 11. A not-taken outcome decrements it and stops at 00. One not-taken outcome from 11 therefore leaves the prediction taken.
- R5: In one-bit mode, each resolve overwrites the indexed entry with the outcome (1 = taken), and pred_taken equals that entry.
- R6: A taken resolve writes the valid bit, the tag res_pc[7:4] and res_target into the indexed target entry, replacing any other branch held there. A not-taken resolve leaves the target store unchanged.
- R7: When a lookup and a resolve hit the same entry in one cycle, the lookup returns the old contents. The update is visible from the next cycle on.
- R8: mispredict is high during a valid resolve in two cases: when the indexed counter's prediction differs from res_taken, or when res_taken is high and res_pc misses in the target store. Both cases use the contents held before that resolve's update.
- R9: Resolving a branch at address 0xD4 with the outcome pattern taken, taken, taken, taken, not taken, run twice from reset, raises mispredict 4 times in one-bit mode and 3 times in two-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 8 | Address being fetched this cycle |
| next_pc | output | 8 | Proposed next fetch address |
| pred_taken | output | 1 | Counter for fetch_pc predicts taken |
| btb_hit | output | 1 | Target entry valid and tag matches fetch_pc |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 8 | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_target | input | 8 | Computed branch target |
| mispredict | output | 1 | Resolving branch was mispredicted |

## Verification
The lookup outputs and mispredict are combinational from table state and the current inputs. The bench therefore drives its inputs on the falling edge and checks those outputs 1 ns later, within the same cycle. A resolve changes the tables only at the next rising edge, so the bench's model applies the update after that edge. The following cycle's checks see the new contents, and any same-cycle lookup sees the old ones. Both counter modes are built side by side and receive the same stimulus. The stimulus consists of address sweeps, the looping-branch sequence, aliasing and same-entry cases, and a long pseudo-random run.

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 2,
  parameter int CTR_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken,
  output logic              btb_hit,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic              mispredict
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;
  localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS-1)) - 1);

  logic [CTR_BITS-1:0] ctr [ENTRIES];
  logic [ENTRIES-1:0]  vld;
  logic [TAG_W-1:0]    tag [ENTRIES];
  logic [ADDR_W-1:0]   tgt [ENTRIES];

  wire [IDX_W-1:0] f_idx = fetch_pc[IDX_W+1:2];
  wire [TAG_W-1:0] f_tag = fetch_pc[ADDR_W-1:IDX_W+2];
  wire [IDX_W-1:0] r_idx = res_pc[IDX_W+1:2];
  wire [TAG_W-1:0] r_tag = res_pc[ADDR_W-1:IDX_W+2];
  wire unused_lsbs = ^{fetch_pc[1:0], res_pc[1:0]};

  wire [CTR_BITS-1:0] r_ctr = ctr[r_idx];
  logic [CTR_BITS-1:0] ctr_nxt;

  assign pred_taken = ctr[f_idx][CTR_BITS-1];
  assign btb_hit    = vld[f_idx] && (tag[f_idx] == f_tag);
  assign next_pc    = (pred_taken && btb_hit) ? tgt[f_idx] : fetch_pc + ADDR_W'(4);

  wire r_pred = r_ctr[CTR_BITS-1];
  wire r_hit  = vld[r_idx] && (tag[r_idx] == r_tag);
  assign mispredict = res_valid && ((r_pred != res_taken) || (res_taken && !r_hit));

  generate
    if (CTR_BITS == 1) begin : g_last
      assign ctr_nxt = res_taken;
      a_r5_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ctr[$past(r_idx)] == $past(res_taken));
    end else begin : g_sat
      always_comb begin
        if (res_taken) ctr_nxt = (r_ctr == CTR_MAX) ? r_ctr : r_ctr + 1'b1;
        else           ctr_nxt = (r_ctr == '0)      ? r_ctr : r_ctr - 1'b1;
      end
      for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
        a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
          (ctr[i] == $past(ctr[i])) ||
          ((ctr[i] == $past(ctr[i]) + 1'b1) && ($past(ctr[i]) != CTR_MAX)) ||
          ((ctr[i] == $past(ctr[i]) - 1'b1) && ($past(ctr[i]) != '0)));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ctr[i] <= CTR_INIT;
        tag[i] <= '0;
        tgt[i] <= '0;
      end
    end else if (res_valid) begin
      ctr[r_idx] <= ctr_nxt;
      if (res_taken) begin
        vld[r_idx] <= 1'b1;
        tag[r_idx] <= r_tag;
        tgt[r_idx] <= res_target;
      end
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !btb_hit);
  a_r6_fill: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_taken |=> vld[$past(r_idx)] && (tag[$past(r_idx)] == $past(r_tag))
                               && (tgt[$past(r_idx)] == $past(res_target)));
  a_r6_nt_keep: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_taken |=> $stable(vld));
  a_r8_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_taken && !r_hit |-> mispredict);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !mispredict);
endmodule

// File: tb/branch_predictor_test.sv
module branch_predictor_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] fetch_pc = 0, res_pc = 0, res_target = 0;
  logic res_valid = 0, res_taken = 0;
  logic [7:0] n2, n1;
  logic p2, p1, h2, h1, m2, m1;

  int total = 0, bad = 0;
  int mc [2][4];
  bit mv [4];
  int mtag [4], mtgt [4];
  bit counting = 0;
  int mis [2];

  branch_predictor #(.CTR_BITS(2)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(n2), .pred_taken(p2),
    .btb_hit(h2), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .mispredict(m2));
  branch_predictor #(.CTR_BITS(1)) uut1 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(n1), .pred_taken(p1),
    .btb_hit(h1), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .mispredict(m1));

  initial forever #(PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(PERIOD*100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit mpred(int m, int idx);
    return (m == 0) ? (mc[0][idx] >= 2) : (mc[1][idx] == 1);
  endfunction

  function automatic bit mhit(logic [7:0] pc);
    return mv[pc[3:2]] && (mtag[pc[3:2]] == int'(pc[7:4]));
  endfunction

  task automatic cyc(string req, bit v, logic [7:0] rpc, bit tk, logic [7:0] rtg, logic [7:0] fpc);
    @(negedge clk);
    res_valid = v; res_pc = rpc; res_taken = tk; res_target = rtg; fetch_pc = fpc;
    #1;
    for (int m = 0; m < 2; m++) begin
      bit ep, eh, em;
      logic [7:0] en;
      ep = mpred(m, fpc[3:2]);
      eh = mhit(fpc);
      en = (ep && eh) ? 8'(mtgt[fpc[3:2]]) : fpc + 8'd4;
      em = v && ((mpred(m, rpc[3:2]) != tk) || (tk && !mhit(rpc)));
      chk(req, m ? "next_pc 1b" : "next_pc 2b", m ? n1 : n2, en);
      chk(req, m ? "pred 1b" : "pred 2b", m ? p1 : p2, ep);
      chk(req, m ? "hit 1b" : "hit 2b", m ? h1 : h2, eh);
      chk(req, m ? "mispredict 1b" : "mispredict 2b", m ? m1 : m2, em);
      if (counting && (m ? m1 : m2)) mis[m]++;
    end
    @(posedge clk);
    if (v) begin
      int i = rpc[3:2];
      mc[0][i] = tk ? ((mc[0][i] == 3) ? 3 : mc[0][i] + 1) : ((mc[0][i] == 0) ? 0 : mc[0][i] - 1);
      mc[1][i] = tk;
      if (tk) begin mv[i] = 1; mtag[i] = rpc[7:4]; mtgt[i] = rtg; end
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      mc[0][i] = 1; mc[1][i] = 0; mv[i] = 0; mtag[i] = 0; mtgt[i] = 0;
    end
    mis[0] = 0; mis[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1, R3: sweep every word address on empty tables
    for (int a = 0; a < 256; a += 4) cyc("R1", 0, 0, 0, 0, 8'(a));

    // R9, R4, R5: looping branch at 0xD4, TTTTN twice
    counting = 1;
    for (int rep = 0; rep < 2; rep++)
      for (int k = 0; k < 5; k++) cyc("R9", 1, 8'hD4, k < 4, 8'hD0, 8'hD4);
    counting = 0;
    chk("R9", "mispredicts 2b", mis[0], 3);
    chk("R9", "mispredicts 1b", mis[1], 4);

    // R2: sweep after training, only tag D matches at index 1
    for (int a = 0; a < 256; a += 4) cyc("R2", 0, 0, 0, 0, 8'(a));

    // R6: alias at index 1 replaces the entry; not-taken leaves index 2 empty
    cyc("R6", 1, 8'h34, 1, 8'h80, 8'hD4);
    cyc("R6", 0, 0, 0, 0, 8'hD4);
    cyc("R6", 0, 0, 0, 0, 8'h34);
    cyc("R6", 1, 8'h58, 0, 8'h10, 8'h58);
    cyc("R6", 0, 0, 0, 0, 8'h58);
    chk("R6", "hit after nt resolve", h2, 0);

    // R7: same-entry lookup and update
    cyc("R7", 1, 8'h0C, 1, 8'h40, 8'h0C);
    cyc("R7", 0, 0, 0, 0, 8'h0C);
    chk("R7", "hit next cycle", h2, 1);

    // R4, R5: hysteresis on index 0
    for (int k = 0; k < 3; k++) cyc("R4", 1, 8'h00, 1, 8'h20, 8'h00);
    cyc("R4", 1, 8'h00, 0, 8'h20, 8'h00);
    cyc("R4", 0, 0, 0, 0, 8'h00);
    chk("R4", "2b still taken", p2, 1);
    chk("R5", "1b flipped", p1, 0);
    chk("R3", "2b redirect", n2, 8'h20);
    chk("R3", "1b fallthrough", n1, 8'h04);

    // R8: pseudo-random resolves and lookups
    for (int k = 0; k < 600; k++)
      cyc("R8", 1'($urandom), 8'($urandom) & 8'hFC, 1'($urandom),
          8'($urandom) & 8'hFC, 8'($urandom) & 8'hFC);

    summary();
    $finish;
  end
endmodule